// File: doc/BRIEF.md
# Serial-Input DAC Code Register

This block is the digital front end of a 16-bit voltage-output converter. A host sends words over a three-wire serial link (an active-low frame select, a serial clock and a data line). Each bit is captured into an input shift register on a rising serial clock edge while the frame is selected. A completed word is copied into a holding register that feeds the converter. The copy happens either when the frame select is released, if the load strobe is tied low, or later, when the active-low load strobe falls while the frame select is high.

All serial pins are treated as slow inputs. They pass through a synchronizer and are edge-detected in the system clock domain. The system clock must run several times faster than the serial clock. The holding register drives three things: the raw 16-bit code, a 15-wire thermometer code made from the top four bits for the segmented upper section, and the low twelve bits for the binary ladder. A synchronous reset clears the holding register to zero. It deliberately leaves the shift register untouched.

Top module: `dac_front_end`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts `din` into bit 0 of the input register and moves the older bits one place toward bit 15. After a 16-bit frame, the first bit sent sits in bit 15.
- R2: With `ldac_n` held low, a rising edge of `cs_n` copies the input register into `dac_code`.
- R3: With `ldac_n` held high through a frame, `dac_code` does not change on the `cs_n` rising edge. A later falling edge of `ldac_n` while `cs_n` is high copies the input register into `dac_code`.
- R4: A frame of more than 16 clocks leaves the last 16 bits received in the input register.
- R5: A frame of n < 16 clocks leaves the previous register contents shifted up by n places, with the n new bits in the low positions.
- R6: Reset does not alter the input register. Bits left there before reset reappear after a short frame that follows reset.
- R7: `sclk` edges and `din` activity while `cs_n` is high change neither the input register nor `dac_code`.
- R8: `seg_en` is a thermometer of the code's top four bits k: bits 0 to k-1 are 1 and the rest are 0.
- R9: `ladder_bits` equals bits 11:0 of `dac_code`.
- R10: While `rst` is high, and in the cycle after it, `dac_code` and `seg_en` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock, rising edge samples data |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe; tie low for load on frame end |
| dac_code | output | 16 | Holding register contents |
| seg_en | output | 15 | Thermometer enables for the upper segments |
| ladder_bits | output | 12 | Low bits for the binary ladder |

## Verification
Some properties are checked on every cycle. One is that the input register holds still while the frame is deselected. Another is that the holding register holds still while the frame is selected. A third is that every load copies the register exactly and every shift lands the sampled bit at bit 0. The thermometer's shape and its population count are also checked against the top bits. Other behaviours need whole frames from the bench to show: MSB-first ordering, keeping the last 16 bits of a long frame, the leftover bits of a short frame, the difference between the two load modes, and that the shift register survives a reset.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int CODE_W   = 16;
    localparam int SEG_BITS = 4;
    localparam int SEG_N    = (1 << SEG_BITS) - 1;
    localparam int LAD_W    = CODE_W - SEG_BITS;

    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [SEG_BITS-1:0] seg_idx_t;
    typedef logic [SEG_N-1:0]    seg_vec_t;
    typedef logic [LAD_W-1:0]    lad_vec_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic ldac_n;
        logic din;
    } ser_pins_t;

    // Idle values: deselected, clock high (no false rising edge),
    // strobe low (no false falling edge when tied low)
    localparam ser_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b1, ldac_n: 1'b0, din: 1'b0};

    typedef struct packed {
        seg_vec_t seg;
        lad_vec_t lad;
    } drive_t;

    function automatic seg_vec_t therm_of(input seg_idx_t k);
        seg_vec_t v;
        for (int i = 0; i < SEG_N; i++) begin
            v[i] = (int'(k) > i);
        end
        return v;
    endfunction

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_fe_shift.sv
module dac_fe_shift
    import dac_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n_s,
    input  logic  sclk_s,
    input  logic  din_s,
    output code_t sr_q
);
    logic sclk_q;
    logic shift_en;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= sclk_s;
    end

    assign shift_en = sclk_s & ~sclk_q & ~cs_n_s;

    // No reset: the input register keeps its contents across reset
    always_ff @(posedge clk) begin
        if (shift_en) sr_q <= {sr_q[CODE_W-2:0], din_s};
    end

    AST_SHIFT_LANDS_BIT0: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr_q[0] == $past(din_s)); // R1

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> $stable(sr_q)); // R7
endmodule

// File: rtl/dac_fe_hold.sv
module dac_fe_hold
    import dac_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n_s,
    input  logic  ldac_n_s,
    input  code_t sr_q,
    output code_t dac_q
);
    logic cs_q;
    logic ldac_q;
    logic cs_rise;
    logic ldac_fall;
    logic load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            ldac_q <= 1'b0;
        end else begin
            cs_q   <= cs_n_s;
            ldac_q <= ldac_n_s;
        end
    end

    assign cs_rise   = cs_n_s & ~cs_q;
    assign ldac_fall = ldac_q & ~ldac_n_s;
    assign load      = (cs_rise & ~ldac_n_s) | (ldac_fall & cs_n_s);

    always_ff @(posedge clk) begin
        if (rst)       dac_q <= '0;
        else if (load) dac_q <= sr_q;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> dac_q == '0); // R10

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        load |=> dac_q == $past(sr_q)); // R2

    AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cs_n_s |=> $stable(dac_q)); // R3
endmodule

// File: rtl/dac_fe_decode.sv
module dac_fe_decode
    import dac_fe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  code_t  code,
    output drive_t drv
);
    seg_idx_t top;
    assign top = code[CODE_W-1 -: SEG_BITS];

    generate
        for (genvar i = 0; i < SEG_N; i++) begin : g_seg
            assign drv.seg[i] = (int'(top) > i);
        end
    endgenerate

    assign drv.lad = code[LAD_W-1:0];

    AST_THERM_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(drv.seg) == int'(top)); // R8

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (drv.seg & (drv.seg + 1'b1)) == '0); // R8

    AST_THERM_FUNC: assert property (@(posedge clk) disable iff (rst)
        drv.seg == therm_of(top)); // R8
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
    import dac_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              ldac_n,
    output logic [CODE_W-1:0] dac_code,
    output logic [SEG_N-1:0]  seg_en,
    output logic [LAD_W-1:0]  ladder_bits
);
    ser_pins_t pins_raw;
    ser_pins_t pins_s;
    code_t     sr_q;
    code_t     dac_q;
    drive_t    drv;

    assign pins_raw = '{cs_n: cs_n, sclk: sclk, ldac_n: ldac_n, din: din};

    dac_fe_sync #(
        .W       ($bits(ser_pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    dac_fe_shift i_shift (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (pins_s.cs_n),
        .sclk_s (pins_s.sclk),
        .din_s  (pins_s.din),
        .sr_q   (sr_q)
    );

    dac_fe_hold i_hold (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (pins_s.cs_n),
        .ldac_n_s (pins_s.ldac_n),
        .sr_q     (sr_q),
        .dac_q    (dac_q)
    );

    dac_fe_decode i_dec (
        .clk  (clk),
        .rst  (rst),
        .code (dac_q),
        .drv  (drv)
    );

    assign dac_code    = dac_q;
    assign seg_en      = drv.seg;
    assign ladder_bits = drv.lad;

    AST_LADDER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ladder_bits == dac_code[LAD_W-1:0]); // R9
endmodule

// File: tb/test_dac_front_end.sv
module test_dac_front_end;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        ldac_n = 1'b0;
    logic [15:0] dac_code;
    logic [14:0] seg_en;
    logic [11:0] ladder_bits;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    dac_front_end i_dac_front_end (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .ldac_n(ldac_n), .dac_code(dac_code), .seg_en(seg_en),
        .ladder_bits(ladder_bits)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift the low n bits of val, MSB first, with cs_n held as given
    task automatic shift_bits(input logic [31:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            din = val[i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [31:0] val, input int n);
        cs_n = 1'b0;
        wait_clk(3);
        shift_bits(val, n);
        wait_clk(3);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        wait_clk(6);
        ldac_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] w;
        wait_clk(4);
        check("R10 code in reset", {16'h0, dac_code}, 32'h0);
        check("R10 seg in reset", {17'h0, seg_en}, 32'h0);
        rst = 1'b0;
        wait_clk(1);
        check("R10 code after reset", {16'h0, dac_code}, 32'h0);

        // R1 R2 R8 R9: sweep every top nibble with ldac tied low
        for (int k = 0; k < 16; k++) begin
            w = {k[3:0], 12'h5A3 ^ 12'(k * 273)};
            frame({16'h0, w}, 16);
            check("R1/R2 code", {16'h0, dac_code}, {16'h0, w});
            check("R8 thermometer", {17'h0, seg_en}, 32'((32'h1 << k) - 1));
            check("R9 ladder", {20'h0, ladder_bits}, {20'h0, w[11:0]});
        end

        // R4: over-length frame keeps last 16 bits
        frame(32'h000ABCDE, 20);
        check("R4 long frame", {16'h0, dac_code}, 32'h0000BCDE);

        // R5: short frame shifts previous contents up
        frame(32'h7, 4);
        check("R5 short frame", {16'h0, dac_code}, 32'h0000CDE7);

        // R3: strobe high through frame, load only on strobe fall
        ldac_n = 1'b1;
        wait_clk(6);
        frame(32'h1234, 16);
        check("R3 no load on cs rise", {16'h0, dac_code}, 32'h0000CDE7);
        pulse_ldac();
        check("R3 load on strobe", {16'h0, dac_code}, 32'h00001234);

        // R7: activity while deselected is ignored
        shift_bits(32'h2AA, 10);
        wait_clk(6);
        check("R7 code unchanged", {16'h0, dac_code}, 32'h00001234);
        pulse_ldac();
        check("R7 register unchanged", {16'h0, dac_code}, 32'h00001234);

        // R6: reset keeps the shift register
        ldac_n = 1'b0;
        wait_clk(6);
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(1);
        check("R10 cleared again", {16'h0, dac_code}, 32'h0);
        frame(32'h9, 4);
        check("R6 bits survive reset", {16'h0, dac_code}, 32'h00002349);
        check("R8 after reset", {17'h0, seg_en}, 32'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule